// File: doc/BRIEF.md
# Three-wire serial EEPROM device (64 x 16)

This block is the memory side of a three-wire serial EEPROM link. A host selects it with a chip-select line, toggles a serial clock and sends bits on a data-in line; the block answers on a data-out line that has its own output-enable. The 64 words of 16 bits are held in registers. All activity is clocked by a fast system clock, and rising edges of the serial clock are found by comparing the serial clock with its value one system cycle earlier.

A transaction opens when chip-select is high and the first serial-clock rise with data-in high arrives. The block then takes a 2-bit opcode and a 6-bit address, and for the two write commands it also takes 16 data bits. Reads stream data out at once and run on into the following words. Commands that change the memory take effect when chip-select falls after a frame of exactly the right length. A write-enable latch guards every such command. After a change to the memory, a programming time is modelled by a busy counter, and the host can poll ready or busy on data-out.

Top module: `uw_eeprom`

## Requirements
- R1: While chip-select is low, the serial clock and data-in are ignored, data-out is not enabled and the memory does not change.
- R2: Serial-clock rises with data-in low before the start bit (data-in high) are discarded, whatever their number.
- R3: After the start bit come a 2-bit opcode, sent as the first bit then the second bit, and a 6-bit address sent MSB first. Opcode 10 reads, 01 writes a word, 11 erases a word, and 00 selects a sub-command from address bits A5:A4.
- R4: READ enables data-out after the rise that samples A0 and drives a 0 there. On each following rise it drives the next bit of the addressed word, MSB first.
- R5: When a READ continues past bit 0, the next word follows with no gap, and the address wraps from 63 to 0.
- R6: WRITE (opcode 01) takes 16 data bits, D15 first, right after A0, and stores them at the address.
- R7: ERASE (opcode 11) sets all 16 bits of the addressed word to 1.
- R8: With opcode 00, A5:A4 = 01 writes the 16 data bits to every word, and A5:A4 = 10 sets every word to all ones. A3:A0 are don't-care.
- R9: With opcode 00, A5:A4 = 11 sets the write-enable latch and 00 clears it. The latch is clear after reset. While it is clear, write, erase, write-all and erase-all change nothing and start no busy period.
- R10: A modifying command takes effect only if exactly 8 bits (for erase and erase-all) or 24 bits (for write and write-all) followed the start bit when chip-select falls. Any other length is discarded.
- R11: After an accepted modifying command, raising chip-select before any new start bit enables data-out. Data-out reads 0 for BUSY_CYCLES system cycles, counted from the cycle in which chip-select fell, and 1 after that.
- R12: While busy, serial-clock rises are ignored, including a start bit, and the status stays on data-out.
- R13: After reset every word reads 16'hFFFF and data-out is not enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data from the host |
| do_o | output | 1 | Serial data or ready/busy status to the host |
| do_oe | output | 1 | Output enable for do_o |

## Verification
A wrong bit counter or a wrong opcode decode shows up in the first read that follows. Either the dummy zero lands on the wrong rise, or the word that comes back differs from the model. A stuck write-enable latch or a bad length check shows up one cycle after chip-select is raised again: a status output appears when none should, or is missing when it should be there. Later reads of the affected words then disagree. Busy-counter faults change the exact cycle at which the status turns to ready, and that cycle is measured precisely.

// File: rtl/uw_eeprom.sv
module uw_eeprom #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int BUSY_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_o,
  output logic do_oe
);
  localparam int DEPTH = 1 << AW;
  localparam int NCMD  = AW + 2;
  localparam int NFULL = NCMD + DW;
  localparam int CW    = $clog2(NFULL + 2);
  localparam int BW    = $clog2(BUSY_CYCLES + 1);
  localparam int IW    = $clog2(DW);

  logic [DEPTH-1:0][DW-1:0] mem;
  logic [NFULL-1:0] sr;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bcnt;
  logic [AW-1:0]    rd_addr;
  logic [IW-1:0]    rd_idx;
  logic sk_q, cs_q, started, rd_mode, rd_dummy, wen, pend;

  wire sk_rise  = sk & ~sk_q;
  wire cs_fall  = cs_q & ~cs;
  wire busy     = bcnt != '0;
  wire short_ok = started && cnt == CW'(NCMD);
  wire long_ok  = started && cnt == CW'(NFULL);
  wire [1:0]    f_op  = long_ok ? sr[NFULL-1 -: 2] : sr[NCMD-1 -: 2];
  wire [AW-1:0] f_adr = long_ok ? sr[NFULL-3 -: AW] : sr[AW-1:0];
  wire [1:0]    f_sub = f_adr[AW-1 -: 2];
  wire [DW-1:0] f_dat = sr[DW-1:0];

  wire do_wr   = long_ok  && f_op == 2'b01;
  wire do_wral = long_ok  && f_op == 2'b00 && f_sub == 2'b01;
  wire do_er   = short_ok && f_op == 2'b11;
  wire do_eral = short_ok && f_op == 2'b00 && f_sub == 2'b10;
  wire do_ewen = short_ok && f_op == 2'b00 && f_sub == 2'b11;
  wire do_ewds = short_ok && f_op == 2'b00 && f_sub == 2'b00;
  wire prog    = cs_fall && wen && (do_wr || do_wral || do_er || do_eral);
  wire rd_go   = cnt == CW'(NCMD-1) && sr[NCMD-2 -: 2] == 2'b10;

  assign do_oe = cs & (rd_mode | (pend & ~started));
  assign do_o  = do_oe & (rd_mode ? (~rd_dummy & mem[rd_addr][rd_idx]) : ~busy);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem <= '1; sr <= '0; cnt <= '0; bcnt <= '0;
      rd_addr <= '0; rd_idx <= '0;
      sk_q <= 1'b0; cs_q <= 1'b0; started <= 1'b0; rd_mode <= 1'b0;
      rd_dummy <= 1'b0; wen <= 1'b0; pend <= 1'b0;
    end else begin
      sk_q <= sk;
      cs_q <= cs;
      if (busy) bcnt <= bcnt - BW'(1);
      if (!cs) begin
        started <= 1'b0;
        cnt     <= '0;
        rd_mode <= 1'b0;
        if (cs_fall) begin
          if (do_ewen) wen <= 1'b1;
          if (do_ewds) wen <= 1'b0;
          if (prog) begin
            bcnt <= BW'(BUSY_CYCLES);
            pend <= 1'b1;
            for (int i = 0; i < DEPTH; i++) begin
              if (do_wral) mem[i] <= f_dat;
              if (do_eral) mem[i] <= '1;
            end
            if (do_wr) mem[f_adr] <= f_dat;
            if (do_er) mem[f_adr] <= '1;
          end
        end
      end else if (sk_rise && !busy) begin
        if (!started) begin
          if (di) begin
            started <= 1'b1;
            pend    <= 1'b0;
          end
        end else begin
          sr <= {sr[NFULL-2:0], di};
          if (cnt != CW'(NFULL+1)) cnt <= cnt + CW'(1);
          if (rd_go) begin
            rd_mode  <= 1'b1;
            rd_dummy <= 1'b1;
            rd_addr  <= {sr[AW-2:0], di};
            rd_idx   <= IW'(DW-1);
          end else if (rd_mode) begin
            if (rd_dummy) rd_dummy <= 1'b0;
            else if (rd_idx == '0) begin
              rd_idx  <= IW'(DW-1);
              rd_addr <= rd_addr + AW'(1);
            end else rd_idx <= rd_idx - IW'(1);
          end
        end
      end
    end
  end

  a_r1_standby_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs && !cs_q) |=> $stable(mem));
  a_r9_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !wen |=> $stable(mem));
  a_r12_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !started);
  a_r11_busy_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> bcnt == $past(bcnt) - BW'(1));
  a_r11_busy_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!cs));
  a_r4_read_framed: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mode |-> started);
endmodule

// File: tb/sim_uw_eeprom.sv
module sim_uw_eeprom;
  localparam int CLK_P = 10;
  localparam int BUSY  = 16;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_o, do_oe;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [15:0] model [64];
  logic wen_m = 1'b0;

  uw_eeprom #(.AW(6), .DW(16), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .do_o(do_o), .do_oe(do_oe));

  always #(CLK_P/2) clk = ~clk;

  function automatic bit is_long(input logic [1:0] op, input logic [5:0] a);
    return op == 2'b01 || (op == 2'b00 && a[5:4] == 2'b01);
  endfunction
  function automatic bit is_mod(input logic [1:0] op, input logic [5:0] a);
    return op == 2'b01 || op == 2'b11 || (op == 2'b00 && (a[5:4] == 2'b01 || a[5:4] == 2'b10));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b, output logic o, output logic oe);
    sk = 1'b0; di = b; tick(2);
    sk = 1'b1; tick(2);
    o = do_o; oe = do_oe;
  endtask

  task automatic cs_off();
    sk = 1'b0; di = 1'b0; tick(1);
    cs = 1'b0; tick(2);
  endtask

  task automatic frame(input int dummies, input logic [31:0] bits, input int n);
    logic o, oe;
    cs = 1'b1; tick(1);
    repeat (dummies) sbit(1'b0, o, oe);
    sbit(1'b1, o, oe);
    for (int i = n - 1; i >= 0; i--) sbit(bits[i], o, oe);
    cs_off();
  endtask

  task automatic wait_ready(input string req);
    int c = 0;
    cs = 1'b1; tick(1);
    check({req, " busy status"}, {30'd0, do_oe, do_o}, 32'h2);
    while (do_o == 1'b0 && c < 100) begin tick(1); c++; end
    check({req, " busy length"}, c, BUSY - 2);
    cs_off();
  endtask

  task automatic no_status(input string req);
    cs = 1'b1; tick(1);
    check({req, " no status"}, {31'd0, do_oe}, 32'h0);
    cs_off();
  endtask

  task automatic read_words(input int addr, input int nw);
    logic o, oe;
    logic [15:0] w;
    logic [7:0] hdr;
    hdr = {2'b10, addr[5:0]};
    cs = 1'b1; tick(1);
    sbit(1'b1, o, oe);
    for (int i = 7; i >= 0; i--) sbit(hdr[i], o, oe);
    check("R4 dummy zero", {30'd0, oe, o}, 32'h2);
    for (int k = 0; k < nw; k++) begin
      w = '0;
      for (int b = 0; b < 16; b++) begin sbit(1'b0, o, oe); w = {w[14:0], o}; end
      check(k == 0 ? "R4 read word" : "R5 sequential word", w, model[(addr + k) % 64]);
    end
    cs_off();
  endtask

  task automatic cmd(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d,
                     input int extra, input int dummies, input string req);
    logic [31:0] bits;
    int n;
    bit lg = is_long(op, a);
    bits = lg ? {8'd0, op, a, d} : {24'd0, op, a};
    n = lg ? 24 : 8;
    if (extra > 0) bits = bits << extra;
    if (extra < 0) bits = bits >> (-extra);
    frame(dummies, bits, n + extra);
    if (extra == 0 && op == 2'b00 && a[5:4] == 2'b11) wen_m = 1'b1;
    if (extra == 0 && op == 2'b00 && a[5:4] == 2'b00) wen_m = 1'b0;
    if (is_mod(op, a)) begin
      if (extra == 0 && wen_m) begin
        case (op)
          2'b01: model[a] = d;
          2'b11: model[a] = 16'hFFFF;
          default: for (int i = 0; i < 64; i++) model[i] = (a[5:4] == 2'b01) ? d : 16'hFFFF;
        endcase
        wait_ready(req);
      end else no_status(req);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic o, oe;
    logic [1:0] op;
    logic [5:0] a;
    int ex;
    void'($urandom(32'h5EED1));
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    tick(4); rst_n = 1'b1; tick(2);
    check("R13 oe after reset", {31'd0, do_oe}, 32'h0);
    read_words(0, 1);
    read_words(63, 1);
    cmd(2'b01, 6'd3, 16'h1234, 0, 0, "R9 write while locked");
    read_words(3, 1);
    cmd(2'b00, 6'b110000, 16'h0, 0, 5, "R9 enable with dummies");
    cmd(2'b01, 6'd5, 16'hA5C3, 0, 7, "R2 R6 write");
    read_words(5, 1);
    // R1: host activity with chip-select low
    cs = 1'b0;
    for (int i = 0; i < 40; i++) sbit(($urandom % 2) == 1 || i < 2, o, oe);
    check("R1 oe with cs low", {31'd0, oe}, 32'h0);
    read_words(5, 1);
    cmd(2'b11, 6'd5, 16'h0, 0, 0, "R7 erase");
    read_words(4, 3);
    cmd(2'b00, 6'b011010, 16'h3C5A, 0, 0, "R8 write all");
    read_words(17, 2);
    cmd(2'b00, 6'b100111, 16'h0, 0, 0, "R8 erase all");
    read_words(40, 2);
    cmd(2'b01, 6'd9, 16'h0F0F, 0, 0, "R6 write");
    cmd(2'b01, 6'd9, 16'h7777, 1, 0, "R10 long write");
    cmd(2'b01, 6'd9, 16'h7777, -1, 0, "R10 short write");
    cmd(2'b11, 6'd9, 16'h0, 1, 0, "R10 long erase");
    read_words(9, 1);
    // R12: start bit while busy is ignored
    cmd(2'b01, 6'd62, 16'hBEEF, 0, 0, "R3 write");
    cmd(2'b01, 6'd63, 16'hCAFE, 0, 0, "R3 write");
    frame(0, {8'd0, 2'b01, 6'd1, 16'h1111}, 24);
    model[1] = 16'h1111;
    cs = 1'b1; tick(1);
    sbit(1'b1, o, oe);
    sbit(1'b1, o, oe);
    check("R12 status kept after start while busy", {30'd0, oe, o}, 32'h2);
    while (do_o == 1'b0) tick(1);
    cs_off();
    read_words(62, 4);
    cmd(2'b00, 6'b000101, 16'h0, 0, 3, "R9 disable");
    cmd(2'b11, 6'd1, 16'h0, 0, 0, "R9 erase while locked");
    cmd(2'b00, 6'b100000, 16'h0, 0, 0, "R9 erase all while locked");
    read_words(0, 2);
    for (int it = 0; it < 60; it++) begin
      case ($urandom % 6)
        0: op = 2'b01;
        1: op = 2'b11;
        2: op = 2'b01;
        default: op = 2'b00;
      endcase
      a = 6'($urandom);
      if (op == 2'b00 && a[5:4] != 2'b11 && ($urandom % 3) != 0) a[5:4] = 2'b11;
      ex = (($urandom % 5) == 0) ? ((($urandom % 2) == 0) ? 1 : -1) : 0;
      cmd(op, a, 16'($urandom), ex, $urandom % 8, "R3 random command");
      if (($urandom % 2) == 0) read_words($urandom % 64, 1 + $urandom % 2);
    end
    read_words(0, 64);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule